// File: doc/BRIEF.md
# Prescaled PWM Timebase with Sleep Control

This block produces the free-running counter that all PWM channels of a multi-channel controller compare against. A programmable prescaler divides the oscillator-rate clock, and the counter advances once every `prescale + 1` clock cycles. With the default 12-bit counter, one PWM period therefore lasts 4096 × (prescale + 1) oscillator cycles. With a 25 MHz oscillator and prescale values from 3 to 255, the period rate runs from about 1526 Hz down to about 24 Hz.

A sleep input stops the timebase. While sleep is set, the counter and the prescale divider are held at zero, and the oscillator-ready flag is low. The prescale register accepts writes only while sleep is set, which keeps every running channel on one consistent period. When sleep is cleared, the block waits a fixed, parameterised oscillator-restart delay before the ready flag rises and counting starts again. After reset the block is asleep.

Top module: `pwm_timebase`

## Requirements
- R1: After reset, `osc_rdy_o` is 0, `cnt_o` is 0 and `roll_o` is 0.
- R2: While `osc_rdy_o` is 1, `cnt_o` advances by one every `P + 1` clock cycles, where P is the prescale register value.
- R3: After its maximum value, `cnt_o` wraps to 0. `roll_o` is high for exactly the one cycle in which `cnt_o` has just wrapped to 0, so rollover pulses are 2^CNT_W × (P + 1) cycles apart.
- R4: A write (`pre_wr_i` = 1) made while `sleep_i` = 1 loads `pre_val_i` into the prescale register at that clock edge.
- R5: A write made while `sleep_i` = 0 is ignored, and the running period does not change.
- R6: A written value below PRE_MIN (default 3) is stored as PRE_MIN.
- R7: Suppose `sleep_i` is sampled low at a clock edge after being high. Then `osc_rdy_o` rises exactly WAKE_CYCLES clock edges later. Until then, `cnt_o` stays 0.
- R8: When `sleep_i` is sampled high, `osc_rdy_o` is 0 after that edge. `cnt_o` and `roll_o` are 0 from the following edge onward, for as long as sleep stays set.
- R9: Setting sleep again during the restart delay cancels the delay. The next clear of sleep starts a full new delay.
- R10: The prescale register resets to PRE_RST (default 30).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | Sleep request. 1 stops the timebase. |
| pre_wr_i | input | 1 | Prescale write strobe |
| pre_val_i | input | PRE_W | Prescale value to write |
| cnt_o | output | CNT_W | Shared PWM counter |
| roll_o | output | 1 | One-cycle pulse when the counter wraps to zero |
| osc_rdy_o | output | 1 | Oscillator ready. The counter runs while this is high. |

## Verification
The bench measures the exact step and rollover intervals after each prescale change. A design with an off-by-one divider would show `P` or `P + 2` cycles per step. A design that accepted writes while awake would change the period after a stray write.

Writing 1 checks the clamp: a design without the clamp would step every two cycles instead of four.

The restart delay is counted to the exact cycle, both from a clean wake and after sleep is re-asserted partway through the delay. A design that kept the partial count would signal ready too early.

Sleep entry is checked for an immediate drop of ready and for the counter being held at zero afterwards.

// File: rtl/pwmtb_pkg.sv
package pwmtb_pkg;
  typedef enum logic [1:0] {
    WK_SLEEP = 2'd0,
    WK_START = 2'd1,
    WK_RUN   = 2'd2
  } wake_st_e;
endpackage

// File: rtl/pwmtb_prescale.sv
module pwmtb_prescale #(
  parameter int PRE_W   = 8,
  parameter int PRE_MIN = 3,
  parameter int PRE_RST = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_i,
  input  logic             wr_i,
  input  logic [PRE_W-1:0] val_i,
  output logic [PRE_W-1:0] pre_o
);
  localparam logic [PRE_W-1:0] MINV = PRE_W'(PRE_MIN);
  localparam logic [PRE_W-1:0] RSTV = PRE_W'(PRE_RST);

  logic [PRE_W-1:0] lim;
  logic [PRE_W-1:0] pre_q;

  generate
    if (PRE_MIN > 0) begin : g_clamp
      always_comb lim = (val_i < MINV) ? MINV : val_i;
    end else begin : g_pass
      always_comb lim = val_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= RSTV;
    end else if (wr_i && sleep_i) begin
      pre_q <= lim;
    end
  end

  assign pre_o = pre_q;

  // R5: register frozen while awake
  p_awake_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !sleep_i |=> $stable(pre_q));
  // R6: never below the minimum
  p_floor_r6: assert property (@(posedge clk) disable iff (rst)
    pre_q >= MINV);
  // R4: accepted write lands next cycle
  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_i && sleep_i && val_i >= MINV) |=> pre_q == $past(val_i));
endmodule

// File: rtl/pwmtb_wake.sv
module pwmtb_wake
  import pwmtb_pkg::*;
#(
  parameter int WAKE_CYCLES = 12500
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_i,
  output logic rdy_o
);
  localparam int WW = $clog2(WAKE_CYCLES + 1);
  localparam logic [WW-1:0] LAST = WW'(WAKE_CYCLES - 1);

  wake_st_e      st_q;
  logic [WW-1:0] wcnt_q;
  logic          rdy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= WK_SLEEP;
      wcnt_q <= '0;
      rdy_q  <= 1'b0;
    end else begin
      case (st_q)
        WK_SLEEP: begin
          rdy_q  <= 1'b0;
          wcnt_q <= '0;
          if (!sleep_i) st_q <= WK_START;
        end
        WK_START: begin
          if (sleep_i) begin
            st_q   <= WK_SLEEP;
            wcnt_q <= '0;
          end else if (wcnt_q == LAST) begin
            st_q  <= WK_RUN;
            rdy_q <= 1'b1;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        WK_RUN: begin
          if (sleep_i) begin
            st_q  <= WK_SLEEP;
            rdy_q <= 1'b0;
          end
        end
        default: begin
          st_q  <= WK_SLEEP;
          rdy_q <= 1'b0;
        end
      endcase
    end
  end

  assign rdy_o = rdy_q;

  // R8: sleep drops ready at the next edge
  p_sleep_drop_r8: assert property (@(posedge clk) disable iff (rst)
    sleep_i |=> !rdy_q);
  // R7: ready only rises out of the restart state
  p_rise_from_start_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_q) |-> $past(st_q) == WK_START);
  // R9: a new restart always begins from a zero count
  p_restart_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (st_q == WK_SLEEP) |=> wcnt_q == '0);
endmodule

// File: rtl/pwmtb_counter.sv
module pwmtb_counter #(
  parameter int CNT_W = 12,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [PRE_W-1:0] pre_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             roll_o
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [PRE_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;
  logic             roll_q;
  logic             tick;

  assign tick = (div_q == pre_i);

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      div_q  <= '0;
      cnt_q  <= '0;
      roll_q <= 1'b0;
    end else if (tick) begin
      div_q  <= '0;
      cnt_q  <= cnt_q + 1'b1;
      roll_q <= (cnt_q == CMAX);
    end else begin
      div_q  <= div_q + 1'b1;
      roll_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign roll_o = roll_q;

  // R8: stopped timebase is held at zero
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (cnt_q == '0 && !roll_q));
  // R3: rollover pulse marks a zero count
  p_roll_at_zero_r3: assert property (@(posedge clk) disable iff (rst)
    roll_q |-> cnt_q == '0);
  // R3: rollover pulse is one cycle wide
  p_roll_single_r3: assert property (@(posedge clk) disable iff (rst)
    roll_q |=> !roll_q);
  // R2: counter never moves by more than one step
  p_step_one_r2: assert property (@(posedge clk) disable iff (rst)
    (run_i && $past(run_i) && cnt_q != $past(cnt_q)) |-> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W       = 12,
  parameter int PRE_W       = 8,
  parameter int PRE_MIN     = 3,
  parameter int PRE_RST     = 30,
  parameter int WAKE_CYCLES = 12500
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_i,
  input  logic             pre_wr_i,
  input  logic [PRE_W-1:0] pre_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             roll_o,
  output logic             osc_rdy_o
);
  logic [PRE_W-1:0] pre;
  logic             rdy;

  pwmtb_prescale #(.PRE_W(PRE_W), .PRE_MIN(PRE_MIN), .PRE_RST(PRE_RST)) u_pre (
    .clk(clk), .rst(rst), .sleep_i(sleep_i), .wr_i(pre_wr_i),
    .val_i(pre_val_i), .pre_o(pre)
  );

  pwmtb_wake #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk(clk), .rst(rst), .sleep_i(sleep_i), .rdy_o(rdy)
  );

  pwmtb_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cnt (
    .clk(clk), .rst(rst), .run_i(rdy), .pre_i(pre),
    .cnt_o(cnt_o), .roll_o(roll_o)
  );

  assign osc_rdy_o = rdy;

  // R7: counter is held at zero while not ready
  p_hold_until_rdy_r7: assert property (@(posedge clk) disable iff (rst)
    !osc_rdy_o |=> (!osc_rdy_o || $past(cnt_o) == '0));
endmodule

// File: tb/sim_pwm_timebase.sv
module sim_pwm_timebase;
  localparam int CW = 4;
  localparam int PW = 8;
  localparam int WK = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sleep_i = 1'b1;
  logic          pre_wr_i = 1'b0;
  logic [PW-1:0] pre_val_i = '0;
  logic [CW-1:0] cnt_o;
  logic          roll_o;
  logic          osc_rdy_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwm_timebase #(.CNT_W(CW), .PRE_W(PW), .PRE_MIN(3), .PRE_RST(30), .WAKE_CYCLES(WK)) u0 (
    .clk(clk), .rst(rst), .sleep_i(sleep_i), .pre_wr_i(pre_wr_i),
    .pre_val_i(pre_val_i), .cnt_o(cnt_o), .roll_o(roll_o), .osc_rdy_o(osc_rdy_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wake_count(output int n);
    sleep_i = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (!osc_rdy_o && cnt_o != 0) chk("R7 cnt held", int'(cnt_o), 0);
    end while (!osc_rdy_o && n < 1000);
  endtask

  task automatic step_len(output int n);
    logic [CW-1:0] p;
    p = cnt_o;
    while (cnt_o == p) @(negedge clk);
    p = cnt_o;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (cnt_o == p && n < 1000);
  endtask

  task automatic go_sleep;
    sleep_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic write_pre(input int v);
    pre_wr_i = 1'b1;
    pre_val_i = PW'(v);
    @(negedge clk);
    pre_wr_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 rdy", int'(osc_rdy_o), 0);
    chk("R1 cnt", int'(cnt_o), 0);
    chk("R1 roll", int'(roll_o), 0);
  endtask

  task automatic t_first_wake;
    int n;
    wake_count(n);
    chk("R7 wake delay", n, WK + 1);
    step_len(n);
    chk("R10 reset prescale step", n, 31);
    chk("R2 step default", n, 31);
  endtask

  task automatic t_ignored_write;
    int n;
    write_pre(5);
    step_len(n);
    chk("R5 write while awake", n, 31);
  endtask

  task automatic t_sleep_entry;
    sleep_i = 1'b1;
    @(negedge clk);
    chk("R8 rdy drop", int'(osc_rdy_o), 0);
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      chk("R8 cnt zero", int'(cnt_o), 0);
      chk("R8 roll zero", int'(roll_o), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_write_asleep;
    int n;
    write_pre(7);
    wake_count(n);
    chk("R7 wake delay 2", n, WK + 1);
    step_len(n);
    chk("R4 step after write", n, 8);
    chk("R2 step p7", n, 8);
    while (!roll_o) @(negedge clk);
    chk("R3 cnt at roll", int'(cnt_o), 0);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!roll_o && n < 1000);
    chk("R3 roll interval", n, 16 * 8);
  endtask

  task automatic t_clamp;
    int n;
    go_sleep();
    write_pre(1);
    wake_count(n);
    step_len(n);
    chk("R6 clamp step", n, 4);
  endtask

  task automatic t_restart;
    int n;
    go_sleep();
    sleep_i = 1'b0;
    repeat (10) @(negedge clk);
    chk("R9 not ready mid delay", int'(osc_rdy_o), 0);
    sleep_i = 1'b1;
    repeat (2) @(negedge clk);
    wake_count(n);
    chk("R9 full delay", n, WK + 1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_first_wake();
    t_ignored_write();
    t_sleep_entry();
    t_write_asleep();
    t_clamp();
    t_restart();
    finish_run();
  end
endmodule